// File: doc/BRIEF.md
# Strobe-Handshake Occupancy FIFO

A 64-word first-in first-out buffer that takes 8- or 9-bit words and is driven by level strobes, not by a pair of read and write enables. The writer raises its shift-in strobe to offer a word and lowers it to finish the transfer. The reader does the same with its shift-out strobe. Both strobes may come from another clock domain. Each one passes through a short synchronizer and then through a two-phase handshake on the block's single clock. An input-ready flag, an output-ready flag and a registered data output close the handshake. Two occupancy flags describe the fill level. One is set from half full upward. The other is set when the buffer is close to either end of its range.

Any number of these FIFOs can be chained to make a deeper buffer. The output-ready flag of one stage drives the shift-in of the next, and the input-ready flag of the next stage drives the shift-out of the one before. Two cases make this chaining work. When a word arrives at an empty buffer whose reader holds shift-out high, output-ready pulses for one clock. When space opens in a full buffer whose writer holds shift-in high, input-ready pulses for one clock and the waiting word is taken. In the 8-bit variant an output-disable input replaces the data output with an idle value of zero and raises a floating indicator.

Top module: `strobe_fifo`

## Requirements
- R1: The word on `din` is captured while `shift_in` is high, and `in_ready` goes low from that point. Lowering `shift_in` commits the word, and `in_ready` then returns high unless 64 words are now held.
- R2: While 64 words are held, `in_ready` stays low. A shift-in strobe given in that state leaves both the contents and the count unchanged.
- R3: While `shift_out` is high on a non-empty buffer, `out_ready` is low. Lowering `shift_out` removes the word on `dout`. The next word then appears with `out_ready` high. If no word is left, `out_ready` stays low and `dout` keeps the removed word.
- R4: Whenever `out_ready` is high, `dout` holds a stored word. That word does not change until `out_ready` has dropped.
- R5: A word committed into an empty buffer while `shift_out` is low appears on `dout`. `out_ready` then stays high until `shift_out` rises.
- R6: A word committed into an empty buffer while `shift_out` is held high raises `out_ready` for exactly one clock, and the word stays on `dout`. Words committed after it do not reach `dout` until `shift_out` goes low.
- R7: Reading a full buffer while `shift_in` is low raises `in_ready`, and it stays high until the next `shift_in` rise.
- R8: Reading a full buffer while `shift_in` is held high raises `in_ready` for exactly one clock. During that clock the word on `din` is taken, and `in_ready` is then low until `shift_in` falls.
- R9: Synchronous reset `rst` empties the buffer. It sets `in_ready` high, `out_ready` low, `dout` to zero, `edge_band` high and `half_full` low.
- R10: If `shift_in` is high when reset is released, the word on `din` is taken at once and `in_ready` stays low until `shift_in` falls.
- R11: `half_full` is high exactly when 32 or more words are held.
- R12: `edge_band` is high exactly when 56 or more words are held or when 8 or fewer are held.
- R13: In the 8-bit variant, `out_disable` high forces `dout` to zero and sets `dout_floating`. It leaves the flags, the contents and the order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| shift_in | input | 1 | Write strobe, asynchronous level |
| shift_out | input | 1 | Read strobe, asynchronous level |
| din | input | DATA_W | Word offered by the writer |
| out_disable | input | 1 | Float request for the data output (8-bit variant only) |
| in_ready | output | 1 | Buffer can take a word |
| out_ready | output | 1 | `dout` holds a valid word |
| dout | output | DATA_W | Head word register |
| dout_floating | output | 1 | Data output is in its idle, floated state |
| half_full | output | 1 | 32 or more words held |
| edge_band | output | 1 | 56 or more, or 8 or fewer, words held |

## Verification
The main function is exercised with a few distinct strobe patterns. A single strobe cycle on a nearly empty buffer separates capture from commit. A full fill followed by a full drain checks word order and every flag threshold, including 8/9, 31/32 and 55/56. Holding `shift_out` high before writing into an empty buffer separates the one-clock fallthrough pulse from the steady ready level. Holding `shift_in` high on a full buffer while one word is read separates the bubblethrough pulse, and it shows that the waiting word lands behind the others. Reset is tried once with data in the buffer and once with `shift_in` high at release, which separates clearing from the immediate capture.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    // Phase of one strobe handshake side
    typedef enum logic {
        PH_OPEN = 1'b0,   // waiting for the strobe to rise
        PH_HELD = 1'b1    // strobe accepted, waiting for its fall
    } hs_phase_t;

    typedef struct packed {
        logic half;
        logic band;
    } occ_flags_t;

    function automatic occ_flags_t occ_eval(input int unsigned cnt,
                                            input int unsigned half_lvl,
                                            input int unsigned high_lvl,
                                            input int unsigned low_lvl);
        occ_flags_t f;
        f.half = (cnt >= half_lvl);
        f.band = (cnt >= high_lvl) || (cnt <= low_lvl);
        return f;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) chain_q[0] <= d;
            end else begin : g_next
                always_ff @(posedge clk) chain_q[i] <= chain_q[i-1];
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/strobe_store.sv
module strobe_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cell_q[waddr] <= wdata;
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/strobe_port_ctrl.sv
module strobe_port_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lvl,     // synchronized strobe level
    input  logic          block,   // no room (write side) or no word (read side)
    output logic          start,   // accept: strobe high while open and unblocked
    output logic          finish,  // complete: strobe low while held
    output logic          ready,
    output logic [AW-1:0] ptr
);
    hs_phase_t ph_q;

    assign start  = lvl && (ph_q == PH_OPEN) && !block;
    assign finish = !lvl && (ph_q == PH_HELD);
    assign ready  = (ph_q == PH_OPEN) && !block;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_OPEN;
            ptr  <= '0;
        end else if (start) begin
            ph_q <= PH_HELD;
        end else if (finish) begin
            ph_q <= PH_OPEN;
            ptr  <= ptr + AW'(1);
        end
    end
endmodule

// File: rtl/strobe_occ.sv
module strobe_occ
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int HALF_LVL = 32,
    parameter int HIGH_LVL = 56,
    parameter int LOW_LVL  = 8,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output occ_flags_t    flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign flags = occ_eval(32'(count), HALF_LVL, HIGH_LVL, LOW_LVL);
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 64,
    parameter int HALF_LVL    = 32,
    parameter int HIGH_LVL    = 56,
    parameter int LOW_LVL     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_in,
    input  logic              shift_out,
    input  logic [DATA_W-1:0] din,
    input  logic              out_disable,
    output logic              in_ready,
    output logic              out_ready,
    output logic [DATA_W-1:0] dout,
    output logic              dout_floating,
    output logic              half_full,
    output logic              edge_band
);
    localparam int AW      = $clog2(DEPTH);
    localparam int CW      = $clog2(DEPTH + 1);
    localparam bit HAS_OE  = (DATA_W == 8);

    logic              si_lvl, so_lvl;
    logic              wr_start, wr_finish, rd_start, rd_finish;
    logic [AW-1:0]     wptr, rptr, head_addr;
    logic [DATA_W-1:0] head_word, dout_q;
    logic [CW-1:0]     count;
    logic              full, empty, head_load;
    occ_flags_t        flags;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_si_sync (.clk(clk), .d(shift_in),  .q(si_lvl));
    strobe_sync #(.STAGES(SYNC_STAGES)) u_so_sync (.clk(clk), .d(shift_out), .q(so_lvl));

    strobe_port_ctrl #(.AW(AW)) u_wr (
        .clk(clk), .rst(rst), .lvl(si_lvl), .block(full),
        .start(wr_start), .finish(wr_finish), .ready(in_ready), .ptr(wptr)
    );

    strobe_port_ctrl #(.AW(AW)) u_rd (
        .clk(clk), .rst(rst), .lvl(so_lvl), .block(empty),
        .start(rd_start), .finish(rd_finish), .ready(out_ready), .ptr(rptr)
    );

    strobe_occ #(
        .DEPTH(DEPTH), .HALF_LVL(HALF_LVL), .HIGH_LVL(HIGH_LVL), .LOW_LVL(LOW_LVL)
    ) u_occ (
        .clk(clk), .rst(rst), .inc(wr_finish), .dec(rd_finish),
        .count(count), .full(full), .empty(empty), .flags(flags)
    );

    // Next head: the word behind the one being removed, or the word
    // being committed into an empty buffer.
    assign head_addr = rd_finish ? (rptr + AW'(1)) : wptr;
    assign head_load = (rd_finish && ((count > CW'(1)) || wr_finish))
                     || (wr_finish && empty);

    strobe_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .we(wr_start), .waddr(wptr), .wdata(din),
        .raddr(head_addr), .rdata(head_word)
    );

    always_ff @(posedge clk) begin
        if (rst)            dout_q <= '0;
        else if (head_load) dout_q <= head_word;
    end

    generate
        if (HAS_OE) begin : g_oe
            assign dout          = out_disable ? '0 : dout_q;
            assign dout_floating = out_disable;
        end else begin : g_no_oe
            logic oe_unused;
            assign oe_unused     = out_disable;
            assign dout          = dout_q;
            assign dout_floating = 1'b0 & oe_unused;
        end
    endgenerate

    assign half_full = flags.half;
    assign edge_band = flags.band;

    // rd_start is consumed inside u_rd; keep it visible for the checker
    logic rd_take;
    assign rd_take = rd_start;
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int CW     = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              si_lvl,
    input logic              so_lvl,
    input logic              in_ready,
    input logic              out_ready,
    input logic              rd_take,
    input logic [DATA_W-1:0] dout,
    input logic [DATA_W-1:0] dout_q,
    input logic              dout_floating,
    input logic              half_full,
    input logic              edge_band,
    input logic [CW-1:0]     count
);
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (count > $past(count)) |-> (count == $past(count) + CW'(1)));

    // R4
    head_stable_chk: assert property (@(posedge clk) disable iff (rst)
        out_ready |=> (!out_ready || $stable(dout_q)));

    // R6
    or_handoff_chk: assert property (@(posedge clk) disable iff (rst)
        (out_ready && so_lvl) |=> !out_ready);

    // R6
    take_drops_or_chk: assert property (@(posedge clk) disable iff (rst)
        rd_take |=> !out_ready);

    // R8
    ir_handoff_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && si_lvl) |=> !in_ready);

    // R9
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_ready && dout == '0 && edge_band && !half_full));

    // R13
    float_idle_chk: assert property (@(posedge clk) disable iff (rst)
        dout_floating |-> (dout == '0));
endmodule

bind strobe_fifo strobe_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) i_chk (
    .clk(clk), .rst(rst), .si_lvl(si_lvl), .so_lvl(so_lvl),
    .in_ready(in_ready), .out_ready(out_ready), .rd_take(rd_take),
    .dout(dout), .dout_q(dout_q), .dout_floating(dout_floating),
    .half_full(half_full), .edge_band(edge_band), .count(count)
);

// File: tb/test_strobe_fifo.sv
`timescale 1ns/1ps
module test_strobe_fifo;
    localparam int W = 8;
    localparam int D = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         si = 1'b0, so = 1'b0, out_dis = 1'b0;
    logic [W-1:0] din = '0;
    logic         ir, orr, flt, hf, band;
    logic [W-1:0] dout;

    int           checks = 0, errors = 0;
    int           ir_hi = 0, or_hi = 0;
    bit           done = 0;
    logic [W-1:0] q[$];
    logic [W-1:0] last = '0;

    always #4 clk = ~clk;

    strobe_fifo i_strobe_fifo (
        .clk(clk), .rst(rst), .shift_in(si), .shift_out(so), .din(din),
        .out_disable(out_dis), .in_ready(ir), .out_ready(orr), .dout(dout),
        .dout_floating(flt), .half_full(hf), .edge_band(band)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            if (ir)  ir_hi++;
            if (orr) or_hi++;
        end
    endtask

    // Compare every port against the queue model
    task automatic cmp(input string tag);
        int n = q.size();
        chk({tag, " in_ready"},  32'(ir),  32'(!si && n < D));
        chk({tag, " out_ready"}, 32'(orr), 32'(!so && n > 0));
        chk({tag, " dout"},      32'(dout), 32'(n > 0 ? q[0] : last));
        chk("R11 half_full",     32'(hf),   32'(n >= 32));
        chk("R12 edge_band",     32'(band), 32'(n >= 56 || n <= 8));
    endtask

    task automatic push(input logic [W-1:0] d, input string tag);
        bit was_full = (q.size() == D);
        din = d;
        si  = 1'b1;
        idle(4);
        cmp(tag);
        si = 1'b0;
        idle(4);
        if (!was_full) q.push_back(d);
        cmp(tag);
    endtask

    task automatic pop(input string tag);
        so = 1'b1;
        idle(4);
        cmp(tag);             // R4: head still shown while out_ready low
        so = 1'b0;
        idle(4);
        if (q.size() > 0) last = q.pop_front();
        cmp(tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst = 1'b0;
        idle(3);
        cmp("R9");
        chk("R9 dout_zero", 32'(dout), 32'h0);

        // R1 / R3: short traffic
        push(8'h11, "R1");
        push(8'h22, "R1");
        push(8'h33, "R1");
        pop("R3");
        pop("R3");
        pop("R3");
        pop("R3");            // R3: read of empty buffer ignored, last word kept
        chk("R3 last_kept", 32'(dout), 32'h33);

        // R1 / R11 / R12: fill to full
        for (int i = 0; i < D; i++) push(W'(i * 5 + 1), "R1");
        push(8'hEE, "R2");    // R2: ignored while full
        chk("R2 full_ir_low", 32'(ir), 32'h0);

        // R7: read a full buffer with shift_in low
        pop("R7");
        idle(10);
        cmp("R7");
        chk("R7 ir_held", 32'(ir), 32'h1);
        push(8'hA5, "R1");

        // R8: read a full buffer with shift_in held high
        din = 8'h5C;
        si  = 1'b1;
        idle(4);
        cmp("R8");
        so = 1'b1;
        idle(4);
        ir_hi = 0;
        so = 1'b0;
        idle(6);
        chk("R8 ir_pulse_len", 32'(ir_hi), 32'h1);
        last = q.pop_front();
        cmp("R8");
        si = 1'b0;
        idle(4);
        q.push_back(8'h5C);
        cmp("R8");

        // R13: output disable
        out_dis = 1'b1;
        idle(2);
        chk("R13 dout_idle", 32'(dout), 32'h0);
        chk("R13 floating",  32'(flt),  32'h1);
        chk("R13 or_kept",   32'(orr),  32'h1);
        chk("R13 band_kept", 32'(band), 32'h1);
        out_dis = 1'b0;
        idle(2);
        chk("R13 floating_off", 32'(flt), 32'h0);
        cmp("R13");

        // R3 / R11 / R12: drain in order
        while (q.size() > 0) pop("R3");
        chk("R3 drained_last", 32'(dout), 32'h5C);

        // R5: fallthrough with shift_out low
        push(8'h71, "R5");
        idle(10);
        cmp("R5");
        chk("R5 or_held", 32'(orr), 32'h1);
        pop("R5");

        // R6: fallthrough with shift_out held high
        so = 1'b1;
        idle(4);
        or_hi = 0;
        push(8'h81, "R6");
        chk("R6 or_pulse_len", 32'(or_hi), 32'h1);
        or_hi = 0;
        push(8'h82, "R6");
        chk("R6 no_second_pulse", 32'(or_hi), 32'h0);
        chk("R6 first_word_held", 32'(dout), 32'h81);
        so = 1'b0;
        idle(4);
        last = q.pop_front();
        cmp("R6");
        pop("R6");

        // R9: reset with data held
        push(8'h91, "R9");
        push(8'h92, "R9");
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(3);
        q.delete();
        last = '0;
        cmp("R9");

        // R10: reset release with shift_in high
        rst = 1'b1;
        din = 8'h5A;
        si  = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(6);
        cmp("R10");
        si = 1'b0;
        idle(4);
        q.push_back(8'h5A);
        cmp("R10");
        chk("R10 word_taken", 32'(dout), 32'h5A);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule